// File: doc/BRIEF.md
# 4x4 Dequantize, Inverse Transform and Reconstruct

This block rebuilds one 4x4 tile of 8-bit pixels from its quantized residual. A start pulse captures sixteen signed coefficients, two per-position matrices (scale and weight), a quantizer shift equal to QP divided by 6, a start-index selector, an external DC value and sixteen 8-bit prediction samples. The block then dequantizes every coefficient. It runs a two-pass integer butterfly transform, first along rows and then along columns. It adds the rounded residual to the prediction and clips the sum to the pixel range.

Each stage is one registered step. A block accepted on one clock edge produces its pixels on the fourth edge after it, together with a one-cycle done pulse. The pixels then stay on the output until the next block completes. While a block is in flight the block reports busy, and any further start is dropped.

Top module: `resid_recon4x4`

## Requirements
- R1: The multiplier for each position is the product of its scale entry and weight entry, truncated to 16 bits and then treated as a signed 16-bit value.
- R2: Each coefficient is multiplied as a signed value by its multiplier into 32 bits, and the product is shifted left by qpShift with wraparound in 32 bits.
- R3: The shifted product has 8 added and is arithmetically shifted right by 4, then saturated to the signed 16-bit range -32768..32767.
- R4: When startIdx equals 1, the dequantized value at position 0 (row 0, column 0) is replaced by dcIn. For any other startIdx the dequantized value is kept.
- R5: The first pass works on each row with 16-bit wrapping arithmetic. For inputs d0..d3 at columns 0..3 it forms e=d0+d2, f=d0-d2, g=(d1>>>1)-d3 and h=d1+(d3>>>1). It outputs e+h, f+g, f-g and e-h to columns 0..3.
- R6: The second pass applies the same butterfly to each column of the first-pass result, taking rows 0..3 as inputs and writing rows 0..3 as outputs. Position index is row*4+column for coefficients, prediction and pixels.
- R7: Each final residual r becomes (r+32)>>>6, computed without overflow. The prediction sample is added and the sum is clipped to 0..255.
- R8: done is high for exactly one cycle, on the fourth clock edge after the edge that accepted start. pixOut changes only on that edge and holds until the next completion.
- R9: A start seen while busy is high is ignored. It does not restart the block and does not change the result.
- R10: After reset, busy and done are low and pixOut is all zeros.
- R11: busy is high from the accepting edge up to the edge that raises done. Start is accepted in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture all inputs and begin a block when idle |
| coefIn | input | 256 | Sixteen signed 16-bit coefficients, position i at bits [16i+15:16i] |
| scaleIn | input | 256 | Sixteen unsigned 16-bit scale entries |
| weightIn | input | 256 | Sixteen unsigned 16-bit weight entries |
| qpShift | input | 4 | Left shift amount applied after the multiply (QP/6) |
| startIdx | input | 4 | A value of 1 selects the external DC for position 0 |
| dcIn | input | 16 | Signed external DC value |
| predIn | input | 128 | Sixteen 8-bit prediction samples, position i at bits [8i+7:8i] |
| busy | output | 1 | A block is in flight |
| done | output | 1 | One-cycle pulse when pixOut is updated |
| pixOut | output | 128 | Sixteen reconstructed 8-bit pixels, same packing as predIn |

## Verification
A zero residual shows that prediction passes through untouched. A lone DC coefficient gives a flat offset, which separates the dequantizer from the butterfly. Large scale and weight products expose 16-bit multiplier truncation, including products that turn negative. Extreme coefficients with a large shift drive both the 16-bit saturation and the pixel clip at each end. Random blocks over several shift values check the row and column ordering of the transform, because a transposed or mirrored pass gives different pixels once the columns differ. Override and non-override start indices, a second start during a run, and a start in the done cycle check the selection, dropping and back-to-back timing.

// File: rtl/recon_pkg.sv
package recon_pkg;

  // Sequencing states of one block pass
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEQ,
    ST_ROW,
    ST_COL,
    ST_REC
  } reconState_t;

  // Strobes from control to datapath, one per pipeline step
  typedef struct packed {
    logic load;
    logic deq;
    logic row;
    logic col;
    logic rec;
  } reconStrobe_t;

endpackage

// File: rtl/recon_bfly4.sv
module recon_bfly4 #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a0,
  input  logic signed [W-1:0] a1,
  input  logic signed [W-1:0] a2,
  input  logic signed [W-1:0] a3,
  output logic signed [W-1:0] y0,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y2,
  output logic signed [W-1:0] y3
);

  logic signed [W-1:0] sumEven, difEven, oddLo, oddHi;

  // Four-point butterfly, all sums wrap at W bits
  always_comb begin
    sumEven = a0 + a2;
    difEven = a0 - a2;
    oddLo   = (a1 >>> 1) - a3;
    oddHi   = a1 + (a3 >>> 1);
    y0 = sumEven + oddHi;
    y1 = difEven + oddLo;
    y2 = difEven - oddLo;
    y3 = sumEven - oddHi;
  end

endmodule

// File: rtl/recon_ctrl.sv
module recon_ctrl
  import recon_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output reconStrobe_t stb,
  output logic         busy,
  output logic         done
);

  reconState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_DEQ;
      ST_DEQ:  stateNext = ST_ROW;
      ST_ROW:  stateNext = ST_COL;
      ST_COL:  stateNext = ST_REC;
      ST_REC:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_REC);
    end
  end

  always_comb begin
    stb.load = (state == ST_IDLE) && start;
    stb.deq  = (state == ST_DEQ);
    stb.row  = (state == ST_ROW);
    stb.col  = (state == ST_COL);
    stb.rec  = (state == ST_REC);
  end

  assign busy = (state != ST_IDLE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ##4 done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(start) && !$past(busy)));

endmodule

// File: rtl/recon_datapath.sv
module recon_datapath
  import recon_pkg::*;
#(
  parameter int COEF_W  = 16,
  parameter int PIX_W   = 8,
  parameter int QSH_W   = 4,
  parameter int IDX_W   = 4,
  parameter int OVR_IDX = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  reconStrobe_t            stb,
  input  logic [16*COEF_W-1:0]    coefIn,
  input  logic [16*COEF_W-1:0]    scaleIn,
  input  logic [16*COEF_W-1:0]    weightIn,
  input  logic [QSH_W-1:0]        qpShift,
  input  logic [IDX_W-1:0]        startIdx,
  input  logic [COEF_W-1:0]       dcIn,
  input  logic [16*PIX_W-1:0]     predIn,
  output logic [16*PIX_W-1:0]     pixOut
);

  localparam int NPOS   = 16;
  localparam int SIDE   = 4;
  localparam int PROD_W = 2 * COEF_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam int DQ_SH  = 4;
  localparam int RC_SH  = 6;
  localparam int REC_W  = COEF_W + 2;

  localparam logic signed [ACC_W-1:0]  DQ_RND  = ACC_W'(1 << (DQ_SH - 1));
  localparam logic signed [ACC_W-1:0]  SAT_MAX = ACC_W'((1 << (COEF_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0]  SAT_MIN = ~SAT_MAX;
  localparam logic signed [COEF_W:0]   RC_RND  = (COEF_W + 1)'(1 << (RC_SH - 1));
  localparam logic signed [REC_W-1:0]  PIX_MAX = REC_W'((1 << PIX_W) - 1);

  // Captured inputs
  logic signed [COEF_W-1:0] coefR   [NPOS];
  logic        [COEF_W-1:0] scaleR  [NPOS];
  logic        [COEF_W-1:0] weightR [NPOS];
  logic        [PIX_W-1:0]  predR   [NPOS];
  logic        [QSH_W-1:0]  qpR;
  logic signed [COEF_W-1:0] dcR;
  logic                     dcSel;

  // Pipeline values
  logic signed [COEF_W-1:0] dqVal [NPOS];
  logic signed [COEF_W-1:0] deqN  [NPOS];
  logic signed [COEF_W-1:0] deqR  [NPOS];
  logic signed [COEF_W-1:0] rowN  [NPOS];
  logic signed [COEF_W-1:0] rowR  [NPOS];
  logic signed [COEF_W-1:0] colN  [NPOS];
  logic signed [COEF_W-1:0] colR  [NPOS];
  logic        [PIX_W-1:0]  pixN  [NPOS];

  always_ff @(posedge clk) begin
    if (stb.load) begin
      for (int i = 0; i < NPOS; i++) begin
        coefR[i]   <= coefIn[i*COEF_W +: COEF_W];
        scaleR[i]  <= scaleIn[i*COEF_W +: COEF_W];
        weightR[i] <= weightIn[i*COEF_W +: COEF_W];
        predR[i]   <= predIn[i*PIX_W +: PIX_W];
      end
      qpR   <= qpShift;
      dcR   <= dcIn;
      dcSel <= (startIdx == IDX_W'(OVR_IDX));
    end
  end

  // Dequantization per position
  for (genvar i = 0; i < NPOS; i++) begin : g_dq
    logic        [COEF_W-1:0] mulT;
    logic signed [PROD_W-1:0] prodT;
    logic signed [PROD_W-1:0] shT;
    logic signed [ACC_W-1:0]  rndT;
    logic signed [ACC_W-1:0]  rsT;

    always_comb begin
      mulT  = scaleR[i] * weightR[i];
      prodT = PROD_W'(coefR[i]) * PROD_W'($signed(mulT));
      shT   = prodT <<< qpR;
      rndT  = ACC_W'(shT) + DQ_RND;
      rsT   = rndT >>> DQ_SH;
      if (rsT > SAT_MAX)
        dqVal[i] = SAT_MAX[COEF_W-1:0];
      else if (rsT < SAT_MIN)
        dqVal[i] = SAT_MIN[COEF_W-1:0];
      else
        dqVal[i] = rsT[COEF_W-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NPOS; i++) deqN[i] = dqVal[i];
    if (dcSel) deqN[0] = dcR;
  end

  always_ff @(posedge clk) begin
    if (stb.deq) deqR <= deqN;
    if (stb.row) rowR <= rowN;
    if (stb.col) colR <= colN;
  end

  // First pass along rows
  for (genvar r = 0; r < SIDE; r++) begin : g_row
    recon_bfly4 #(.W(COEF_W)) u_bf (
      .a0(deqR[SIDE*r]),   .a1(deqR[SIDE*r+1]),
      .a2(deqR[SIDE*r+2]), .a3(deqR[SIDE*r+3]),
      .y0(rowN[SIDE*r]),   .y1(rowN[SIDE*r+1]),
      .y2(rowN[SIDE*r+2]), .y3(rowN[SIDE*r+3])
    );
  end

  // Second pass along columns
  for (genvar c = 0; c < SIDE; c++) begin : g_col
    recon_bfly4 #(.W(COEF_W)) u_bf (
      .a0(rowR[c]),          .a1(rowR[SIDE+c]),
      .a2(rowR[2*SIDE+c]),   .a3(rowR[3*SIDE+c]),
      .y0(colN[c]),          .y1(colN[SIDE+c]),
      .y2(colN[2*SIDE+c]),   .y3(colN[3*SIDE+c])
    );
  end

  // Rounding, prediction add and clip
  for (genvar i = 0; i < NPOS; i++) begin : g_rec
    logic signed [COEF_W:0]  rrT;
    logic signed [REC_W-1:0] sumT;

    always_comb begin
      rrT  = ((COEF_W + 1)'(colR[i]) + RC_RND) >>> RC_SH;
      sumT = REC_W'(rrT) + REC_W'($signed({1'b0, predR[i]}));
      if (sumT < 0)
        pixN[i] = '0;
      else if (sumT > PIX_MAX)
        pixN[i] = '1;
      else
        pixN[i] = sumT[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut <= '0;
    end else if (stb.rec) begin
      for (int i = 0; i < NPOS; i++) pixOut[i*PIX_W +: PIX_W] <= pixN[i];
    end
  end

  // R4
  dc_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.deq && dcSel) |=> (deqR[0] == $past(dcR)));

  // R3
  deq_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.deq && !dcSel && (coefR[0] == '0)) |=> (deqR[0] == '0));

endmodule

// File: rtl/resid_recon4x4.sv
module resid_recon4x4
  import recon_pkg::*;
#(
  parameter int COEF_W  = 16,
  parameter int PIX_W   = 8,
  parameter int QSH_W   = 4,
  parameter int IDX_W   = 4,
  parameter int OVR_IDX = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [16*COEF_W-1:0]  coefIn,
  input  logic [16*COEF_W-1:0]  scaleIn,
  input  logic [16*COEF_W-1:0]  weightIn,
  input  logic [QSH_W-1:0]      qpShift,
  input  logic [IDX_W-1:0]      startIdx,
  input  logic [COEF_W-1:0]     dcIn,
  input  logic [16*PIX_W-1:0]   predIn,
  output logic                  busy,
  output logic                  done,
  output logic [16*PIX_W-1:0]   pixOut
);

  reconStrobe_t stb;

  recon_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stb  (stb),
    .busy (busy),
    .done (done)
  );

  recon_datapath #(
    .COEF_W (COEF_W),
    .PIX_W  (PIX_W),
    .QSH_W  (QSH_W),
    .IDX_W  (IDX_W),
    .OVR_IDX(OVR_IDX)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .coefIn  (coefIn),
    .scaleIn (scaleIn),
    .weightIn(weightIn),
    .qpShift (qpShift),
    .startIdx(startIdx),
    .dcIn    (dcIn),
    .predIn  (predIn),
    .pixOut  (pixOut)
  );

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(pixOut));

endmodule

// File: tb/sim_resid_recon4x4.sv
module sim_resid_recon4x4;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYC     = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [255:0] coefIn = '0;
  logic [255:0] scaleIn = '0;
  logic [255:0] weightIn = '0;
  logic [3:0]   qpShift = '0;
  logic [3:0]   startIdx = '0;
  logic [15:0]  dcIn = '0;
  logic [127:0] predIn = '0;
  logic         busy, done;
  logic [127:0] pixOut;

  int checks = 0;
  int fails  = 0;
  bit running = 0;
  bit finished = 0;
  string curReq = "R10";

  // reference model state
  bit           mBusy = 0;
  bit           mDone = 0;
  int           mCnt  = 0;
  logic [127:0] mPix  = '0;
  logic [127:0] mNext = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resid_recon4x4 u0 (
    .clk(clk), .rstN(rstN), .start(start), .coefIn(coefIn),
    .scaleIn(scaleIn), .weightIn(weightIn), .qpShift(qpShift),
    .startIdx(startIdx), .dcIn(dcIn), .predIn(predIn),
    .busy(busy), .done(done), .pixOut(pixOut)
  );

  function automatic void bfly(input shortint a0, input shortint a1,
                               input shortint a2, input shortint a3,
                               output shortint y0, output shortint y1,
                               output shortint y2, output shortint y3);
    shortint e, f, g, h;
    e = a0 + a2;
    f = a0 - a2;
    g = (a1 >>> 1) - a3;
    h = a1 + (a3 >>> 1);
    y0 = e + h; y1 = f + g; y2 = f - g; y3 = e - h;
  endfunction

  function automatic logic [127:0] refBlock();
    shortint d[16], f[16], g[16];
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      int m, p, q;
      longint r;
      m = (int'(scaleIn[i*16 +: 16]) * int'(weightIn[i*16 +: 16])) & 32'hFFFF;   // R1
      if (m > 32767) m = m - 65536;
      p = int'(shortint'(coefIn[i*16 +: 16])) * m;                                // R2
      q = p << qpShift;
      r = (longint'(q) + 8) >>> 4;                                                // R3
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      d[i] = shortint'(r);
    end
    if (startIdx == 4'd1) d[0] = shortint'(dcIn);                                 // R4
    for (int r = 0; r < 4; r++)                                                   // R5
      bfly(d[4*r], d[4*r+1], d[4*r+2], d[4*r+3], f[4*r], f[4*r+1], f[4*r+2], f[4*r+3]);
    for (int c = 0; c < 4; c++)                                                   // R6
      bfly(f[c], f[4+c], f[8+c], f[12+c], g[c], g[4+c], g[8+c], g[12+c]);
    for (int i = 0; i < 16; i++) begin
      int s;
      s = ((int'(g[i]) + 32) >>> 6) + int'(predIn[i*8 +: 8]);                     // R7
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      res[i*8 +: 8] = 8'(s);
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mPix = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt++;
        if (mCnt == 4) begin
          mBusy = 0; mDone = 1; mPix = mNext;
        end
      end else if (start) begin
        mNext = refBlock();
        mBusy = 1;
        mCnt  = 0;
      end
    end
  end

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkPix(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pixOut actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      checkBit("R8", "done", done, mDone);
      checkBit("R11", "busy", busy, mBusy);
      checkPix(curReq, pixOut, mPix);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic setUniform(input int sc, input int wt, input int qp, input int idx);
    for (int i = 0; i < 16; i++) begin
      scaleIn[i*16 +: 16]  = 16'(sc);
      weightIn[i*16 +: 16] = 16'(wt);
    end
    qpShift = 4'(qp);
    startIdx = 4'(idx);
  endtask

  task automatic setPredRamp(input int base, input int step);
    for (int i = 0; i < 16; i++) predIn[i*8 +: 8] = 8'(base + step * i);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runBlock();
    @(negedge clk);
    pulseStart();
    repeat (6) @(negedge clk);
  endtask

  task automatic randFill(input int span);
    for (int i = 0; i < 16; i++) begin
      int v;
      v = int'($urandom_range(0, 2 * span)) - span;
      coefIn[i*16 +: 16]   = v[15:0];
      scaleIn[i*16 +: 16]  = 16'($urandom_range(10, 25));
      weightIn[i*16 +: 16] = 16'($urandom_range(8, 24));
      predIn[i*8 +: 8]     = 8'($urandom_range(0, 255));
    end
    qpShift = 4'($urandom_range(0, 5));
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=hang expected=completion");
      summary();
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R10 reset state
    checkBit("R10", "busy", busy, 1'b0);
    checkBit("R10", "done", done, 1'b0);
    checkPix("R10", pixOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    running = 1;

    // R7 zero residual passes prediction through
    curReq = "R7";
    coefIn = '0; setUniform(16, 16, 0, 0); setPredRamp(3, 16);
    runBlock();

    // R2 R5 R6 lone DC coefficient gives a flat offset
    curReq = "R2/R5/R6";
    coefIn = '0; coefIn[15:0] = 16'd10; setUniform(16, 16, 2, 0); setPredRamp(100, 0);
    runBlock();

    // R1 multiplier truncation above 16 bits
    curReq = "R1";
    coefIn = '0; coefIn[15:0] = 16'd1; coefIn[31:16] = 16'd2;
    setUniform(300, 300, 0, 0); setPredRamp(128, 1);
    runBlock();

    // R1 truncated product that reads as negative
    setUniform(200, 200, 1, 0);
    runBlock();

    // R3 saturation at both ends, with R7 clip
    curReq = "R3";
    for (int i = 0; i < 16; i++) coefIn[i*16 +: 16] = (i % 2 == 0) ? 16'sd30000 : -16'sd30000;
    setUniform(16, 16, 8, 0); setPredRamp(0, 17);
    runBlock();
    coefIn = '0; coefIn[15:0] = 16'sd30000;
    runBlock();
    coefIn[15:0] = -16'sd30000;
    runBlock();

    // R4 external DC override and non-override index
    curReq = "R4";
    coefIn = '0; coefIn[15:0] = 16'd40; coefIn[47:32] = 16'd5;
    setUniform(16, 16, 1, 1); dcIn = -16'sd500; setPredRamp(90, 5);
    runBlock();
    startIdx = 4'd2;
    runBlock();
    startIdx = 4'd0; dcIn = 16'sd900;
    runBlock();

    // R5 R6 random blocks distinguish row and column order
    curReq = "R5/R6";
    for (int n = 0; n < 24; n++) begin
      randFill((n % 3 == 0) ? 600 : 60);
      startIdx = (n % 5 == 0) ? 4'd1 : 4'd3;
      dcIn = 16'($urandom_range(0, 2000)) - 16'd1000;
      runBlock();
    end

    // R9 start during busy is dropped
    curReq = "R9";
    randFill(80);
    @(negedge clk);
    pulseStart();
    @(negedge clk);
    randFill(300);
    pulseStart();
    repeat (6) @(negedge clk);

    // R11 start accepted in the done cycle
    curReq = "R11";
    randFill(100);
    @(negedge clk);
    pulseStart();
    while (!done) @(negedge clk);
    randFill(100);
    pulseStart();
    repeat (8) @(negedge clk);

    running = 0;
    summary();
  end

endmodule